// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from the module clock. One 32-bit control word picks one of two divide laws. A linear law divides by 2*(N+1), where N is an 8-bit field. An exponential law divides by 2^E, where E is a 4-bit field. A select bit switches between the two laws at runtime. The block drives a 50% duty SCK level. It also drives two one-cycle strobes that mark the leading edge (SCK leaves its idle level) and the trailing edge (SCK returns to idle), so a shift engine in the module clock domain can act on them.

A run input gates the block. While run is low the counters are held clear and SCK rests at the idle polarity given on its own input. When run rises, the first leading edge comes one full half-period later. A new control word is taken up only at a half-period boundary, so a change in the middle of a transfer never produces a shortened pulse. With E equal to 0 in exponential mode, the ratio is 1. In that case both strobes fire on every running cycle and SCK stays at idle, since the shift engine then runs at the module rate.

Top module: `spi_sck_divider`

## Requirements
- R1: With control bit 12 set, bits 7:0 give N and each SCK half-period lasts N+1 module cycles (ratio 2 to 512); bits 11:8 have no effect in this mode.
- R2: With control bit 12 clear and bits 11:8 giving E from 1 to 15, each SCK half-period lasts 2^(E-1) module cycles; bits 7:0 have no effect in this mode.
- R3: With bit 12 clear and E equal to 0, the leading and trailing strobes are both high on every cycle while running, and SCK stays at the idle level.
- R4: Outside the R3 case, each strobe is high for exactly one cycle per edge, the two strobes never coincide, and they alternate starting with the leading strobe.
- R5: While run is low, SCK equals the idle polarity, both strobes are low and the counters clear. After run rises, with the control word already applied for at least one cycle, the first leading strobe and SCK change appear in the H-th cycle, where H is the half-period.
- R6: A control word change while running takes effect only at the next half-period boundary; the half-period in progress finishes at the old length.
- R7: SCK equals the idle polarity input when idle. A leading strobe coincides with SCK moving to the opposite level, and a trailing strobe coincides with its return.
- R8: Control bits 31:13 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables clock generation; low holds the divider clear |
| idle_pol | input | 1 | Level SCK rests at when idle |
| clk_ctrl | input | 32 | Clock control word (N in 7:0, E in 11:8, law select in 12) |
| sck | output | 1 | Divided serial clock level |
| lead_stb | output | 1 | One-cycle strobe at each leading SCK edge |
| trail_stb | output | 1 | One-cycle strobe at each trailing SCK edge |

## Verification
The properties assume that idle_pol holds steady while run is high, and that a control word is present for at least one cycle before run rises. Without those two conditions the SCK stability and first-edge timing would not be defined. The stimulus writes the control word and the polarity at a falling clock edge, waits one full cycle, and only then raises run. Mid-run changes touch only the control word, never the polarity. Random control words keep E at 8 or below so that every window stays short, and the large exponent and the largest linear value are covered by directed cases.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

  // Module cycles per SCK half-period for a decoded control word.
  function automatic int unsigned half_len(input int unsigned lin_n,
                                           input int unsigned exp_e,
                                           input logic        lin_sel);
    int unsigned h;
    if (lin_sel)       h = lin_n + 1;
    else if (exp_e == 0) h = 1;
    else               h = 1 << (exp_e - 1);
    return h;
  endfunction

  // Ratio of one: strobes run at module rate.
  function automatic logic is_full_rate(input int unsigned exp_e,
                                        input logic        lin_sel);
    return (!lin_sel) && (exp_e == 0);
  endfunction

endpackage

// File: rtl/spi_div_decode.sv
module spi_div_decode #(
  parameter int CTRL_W  = 32,
  parameter int LIN_LSB = 0,
  parameter int LIN_W   = 8,
  parameter int EXP_LSB = 8,
  parameter int EXP_W   = 4,
  parameter int SEL_BIT = 12,
  parameter int CNT_W   = 15
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic [CNT_W-1:0]  half_next,
  output logic              full_next
);
  import spi_div_pkg::*;

  logic [LIN_W-1:0] lin_f;
  logic [EXP_W-1:0] exp_f;
  logic             sel_f;

  assign lin_f = ctrl[LIN_LSB +: LIN_W];
  assign exp_f = ctrl[EXP_LSB +: EXP_W];
  assign sel_f = ctrl[SEL_BIT];

  always_comb begin
    half_next = CNT_W'(half_len(int'(lin_f), int'(exp_f), sel_f));
    full_next = is_full_rate(int'(exp_f), sel_f);
  end
endmodule

// File: rtl/spi_div_counter.sv
module spi_div_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_next,
  input  logic             full_next,
  output logic             boundary,
  output logic [CNT_W-1:0] h_cur,
  output logic             full_cur
);
  logic [CNT_W-1:0] cnt;

  assign boundary = run && (cnt == (h_cur - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      h_cur    <= CNT_W'(1);
      full_cur <= 1'b0;
    end else if (!run || boundary) begin
      cnt      <= '0;
      h_cur    <= half_next;
      full_cur <= full_next;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi_div_phase.sv
module spi_div_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic boundary,
  input  logic full_cur,
  input  logic idle_pol,
  output logic sck,
  output logic lead_stb,
  output logic trail_stb
);
  logic active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (!run) begin
      active    <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (boundary && full_cur) begin
      active    <= 1'b0;
      lead_stb  <= 1'b1;
      trail_stb <= 1'b1;
    end else if (boundary) begin
      active    <= !active;
      lead_stb  <= !active;
      trail_stb <= active;
    end else begin
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end
  end

  assign sck = idle_pol ^ active;
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
  parameter int CTRL_W  = 32,
  parameter int LIN_LSB = 0,
  parameter int LIN_W   = 8,
  parameter int EXP_LSB = 8,
  parameter int EXP_W   = 4,
  parameter int SEL_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              idle_pol,
  input  logic [CTRL_W-1:0] clk_ctrl,
  output logic              sck,
  output logic              lead_stb,
  output logic              trail_stb
);
  localparam int EXP_CW = (1 << EXP_W) - 1;
  localparam int CNT_W  = (LIN_W + 1 > EXP_CW) ? LIN_W + 1 : EXP_CW;

  logic [CNT_W-1:0] half_next;
  logic             full_next;
  logic             boundary;
  logic [CNT_W-1:0] h_cur;
  logic             full_cur;

  spi_div_decode #(
    .CTRL_W(CTRL_W), .LIN_LSB(LIN_LSB), .LIN_W(LIN_W),
    .EXP_LSB(EXP_LSB), .EXP_W(EXP_W), .SEL_BIT(SEL_BIT), .CNT_W(CNT_W)
  ) u_decode (
    .ctrl(clk_ctrl), .half_next(half_next), .full_next(full_next)
  );

  spi_div_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .run(run),
    .half_next(half_next), .full_next(full_next),
    .boundary(boundary), .h_cur(h_cur), .full_cur(full_cur)
  );

  spi_div_phase u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .boundary(boundary),
    .full_cur(full_cur), .idle_pol(idle_pol),
    .sck(sck), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );
endmodule

// File: rtl/spi_sck_divider_chk.sv
module spi_sck_divider_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             idle_pol,
  input logic             sck,
  input logic             lead_stb,
  input logic             trail_stb,
  input logic             boundary,
  input logic             full_cur,
  input logic [CNT_W-1:0] h_cur
);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb && trail_stb) |-> full_cur);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!lead_stb && !trail_stb && sck == idle_pol));

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !boundary) |=> $stable(h_cur));

  assert_lead_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb && !trail_stb) |-> (sck != idle_pol));

  assert_trail_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_stb && !lead_stb) |-> (sck == idle_pol));

  assert_sck_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !lead_stb && !trail_stb && $stable(idle_pol))
      |-> $stable(sck));
endmodule

bind spi_sck_divider spi_sck_divider_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .idle_pol(idle_pol), .sck(sck),
  .lead_stb(lead_stb), .trail_stb(trail_stb), .boundary(boundary),
  .full_cur(full_cur), .h_cur(h_cur)
);

// File: tb/spi_sck_divider_test.sv
`timescale 1ns/1ps
module spi_sck_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        idle_pol = 1'b0;
  logic [31:0] clk_ctrl = '0;
  logic        sck, lead_stb, trail_stb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_sck_divider uut (
    .clk(clk), .rst_n(rst_n), .run(run), .idle_pol(idle_pol),
    .clk_ctrl(clk_ctrl), .sck(sck), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  // Total divide ratio from the control word, written as the laws state it.
  function automatic int ratio_of(input logic [31:0] w);
    if (w[12]) return 2 * (int'(w[7:0]) + 1);
    return 2 ** int'(w[11:8]);
  endfunction

  task automatic chk(input string req, input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, expv);
    end
  endtask

  task automatic stop_run();
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
  endtask

  // Apply a word, then start, then check ncyc cycles against the ideal wave.
  task automatic window(input string req, input logic [31:0] w, input logic pol, input int nhalf);
    int r, h;
    logic el, et, es;
    r = ratio_of(w);
    h = (r == 1) ? 1 : r / 2;
    @(negedge clk);
    clk_ctrl = w;
    idle_pol = pol;
    @(negedge clk);
    run = 1'b1;
    for (int i = 1; i <= h * nhalf; i++) begin
      @(posedge clk);
      #2;
      if (r == 1) begin
        el = 1'b1; et = 1'b1; es = pol;
      end else begin
        el = (i % (2 * h)) == h;
        et = (i % (2 * h)) == 0;
        es = pol ^ (((i / h) % 2) == 1);
      end
      chk(req, lead_stb, el, "lead_stb");
      chk(req, trail_stb, et, "trail_stb");
      chk(req, sck, es, "sck");
    end
    stop_run();
    chk("R5", sck, pol, "sck idle after stop");
    chk("R5", lead_stb, 1'b0, "lead idle after stop");
  endtask

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20240611));
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: reset and idle state
    chk("R5", sck, 1'b0, "sck after reset");
    chk("R5", lead_stb, 1'b0, "lead after reset");
    chk("R5", trail_stb, 1'b0, "trail after reset");
    idle_pol = 1'b1;
    #1;
    chk("R7", sck, 1'b1, "sck follows idle polarity");

    // R1 directed: smallest and largest linear ratios
    window("R1", 32'h0000_1000, 1'b0, 4);
    window("R1", 32'h0000_10FF, 1'b1, 3);
    // R2 directed: E=1, E=5, E=15
    window("R2", 32'h0000_0100, 1'b0, 4);
    window("R2", 32'h0000_05A7, 1'b1, 4);
    window("R2", 32'h0000_0F00, 1'b0, 2);
    // R3: ratio one, with N bits set (ignored)
    window("R3", 32'h0000_00C3, 1'b0, 6);
    window("R3", 32'h0000_0000, 1'b1, 6);
    // R8: garbage in 31:13 and in the unused field
    window("R8", 32'hFFFF_EF01, 1'b0, 4);
    window("R8", 32'hA5A5_C2FF, 1'b1, 4);

    // R4 / R1 / R2: random words
    for (int k = 0; k < 16; k++) begin
      w = $urandom;
      if (!w[12]) w[11:8] = 4'($urandom_range(8, 1));
      window(w[12] ? "R1" : "R2", w, 1'($urandom), 5);
    end
    window("R4", 32'h0000_1002, 1'b0, 8);

    // R5: drop run mid half-period, then restart with full first half-period
    @(negedge clk);
    clk_ctrl = 32'h0000_1004;
    idle_pol = 1'b0;
    @(negedge clk);
    run = 1'b1;
    repeat (7) @(posedge clk);
    #2;
    chk("R5", sck, 1'b1, "sck active before stop");
    @(negedge clk);
    run = 1'b0;
    @(posedge clk);
    #2;
    chk("R5", sck, 1'b0, "sck idle once run low");
    chk("R5", trail_stb, 1'b0, "no trail strobe on stop");
    window("R5", 32'h0000_1004, 1'b0, 2);

    // R6: change H 3 -> 5 after the first leading edge
    @(negedge clk);
    clk_ctrl = 32'h0000_1002;
    idle_pol = 1'b0;
    @(negedge clk);
    run = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      @(posedge clk);
      #2;
      chk("R6", lead_stb, (i == 3 || i == 11), "lead_stb");
      chk("R6", trail_stb, (i == 6 || i == 16), "trail_stb");
      chk("R6", sck, ((i >= 3 && i < 6) || (i >= 11 && i < 16)), "sck");
      if (i == 4) begin
        @(negedge clk);
        clk_ctrl = 32'h0000_1004;
      end
    end
    stop_run();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule